// File: doc/BRIEF.md
# Host Adapter Register Port

This block is the adapter side of a small byte-wide register window through which a host drives a storage host adapter. Three offsets are decoded, and reads and writes at the same offset mean different things. Offset 0 takes control writes and returns status. Offset 1 takes opcode and parameter bytes and returns reply bytes. Offset 2 returns the interrupt register. A command engine collects the parameter bytes of each supported opcode and streams the reply bytes back one at a time. When a command finishes it raises a command-complete interrupt. An unknown opcode is flagged as invalid.

Reply contents come from static configuration inputs. A mailbox-initialisation command latches the mailbox count, the base address and the addressing width onto output ports. A start-mailbox opcode produces a one-cycle scan pulse for the mailbox engine that sits outside this block. Two event inputs let that engine post its mailbox interrupts. A hard reset, written through the control register or applied through `rst_n`, holds the diagnostic-active state for `SETTLE_CYCLES` cycles. The status register then reads 0x30.

Top module: `hba_regport`

## Requirements
- R1: After reset is released, status reads 0x80 (diagnostic active) for exactly SETTLE_CYCLES cycles and then 0x30 (initialisation required plus ready). The interrupt register reads 0x00 throughout.
- R2: A control write with bit 7 set clears the interrupt register, abandons any command and restarts the settle sequence of R1. Writes to offset 1 made during the settle are ignored.
- R3: A control write with bit 6 set and bit 7 clear aborts the current command and clears the interrupt register and the data-in ready flag. Status reads 0x30 in the next cycle.
- R4: A control write with bit 5 set clears the interrupt register. A control write with bit 4 set pulses `scsi_bus_rst_o` for one cycle and sets interrupt bit 3.
- R5: Interrupt bit 7 is set exactly when any of interrupt bits 0 to 3 is set, and `irq_o` follows it.
- R6: Status bit 3 (busy) is high for exactly one cycle after each byte accepted at offset 1, and a write to offset 1 in that cycle is ignored. Status bit 4 (ready) is low from the opcode until command complete.
- R7: Opcode 0x01 takes 4 parameter bytes: the mailbox count, then a 24-bit base address most significant byte first. It updates `mbox_count_o`, `mbox_base_o` and `mbox_ext_o`=0, clears status bit 5 and sets interrupt bit 2 (command complete).
- R8: Opcode 0x81 takes 5 parameter bytes: the mailbox count, then a 32-bit base address least significant byte first. It sets `mbox_ext_o`=1, clears status bit 5 and sets command complete.
- R9: Opcode 0x04 returns the 4 bytes of `cfg_board_id`, lowest byte first. Opcode 0x0B returns the 3 bytes of `cfg_setup`, lowest byte first.
- R10: Opcode 0x8D takes a length byte N and returns N bytes. Byte 0 is 0x45 when `cfg_ext32` is 1 and 0x41 otherwise, byte 13 is {7'b0, `cfg_wide`}, and all other bytes are 0. When N is 0 the command completes with no reply.
- R11: Status bit 2 (data-in ready) clears when offset 1 is read and sets again when the next reply byte is loaded. Command complete is raised only after the last reply byte has been read.
- R12: Opcode 0x02, written while no command is in progress, pulses `mbox_scan_o` for one cycle. It does not lower the ready bit and does not set command complete.
- R13: Any other opcode sets status bit 0 (invalid) together with command complete and returns to ready. Bit 0 clears when the next opcode is accepted.
- R14: A pulse on `evt_in_loaded` sets interrupt bit 0, and a pulse on `evt_out_ready` sets interrupt bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as a hard reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe; pops data-in at offset 1 |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed offset |
| irq_o | output | 1 | Interrupt request (interrupt bit 7) |
| evt_in_loaded | input | 1 | Incoming-mailbox-loaded event |
| evt_out_ready | input | 1 | Outgoing-mailbox-ready event |
| cfg_board_id | input | 32 | Reply bytes of opcode 0x04 |
| cfg_setup | input | 24 | Reply bytes of opcode 0x0B |
| cfg_ext32 | input | 1 | Selects the 32-bit marker in the 0x8D reply |
| cfg_wide | input | 1 | Wide flag in the 0x8D reply |
| mbox_scan_o | output | 1 | One-cycle mailbox scan request |
| scsi_bus_rst_o | output | 1 | One-cycle SCSI bus reset request |
| mbox_count_o | output | 8 | Latched mailbox count |
| mbox_base_o | output | 32 | Latched mailbox base address |
| mbox_ext_o | output | 1 | 1 when the mailboxes were set up with 32-bit addresses |

## Verification
The engine is exercised with commands of four shapes: parameters only (both initialisation forms), reply only (0x04 and 0x0B), a parameter that sets the reply length (0x8D with lengths 14, 2 and 0), and single-byte opcodes (start-mailbox and an unknown code).

- The two initialisation forms use mirrored byte orders, so a swapped address byte shows up in `mbox_base_o`.
- The 0x8D runs with both configuration settings separate the marker byte and the wide bit from the zero filler.
- A byte written during the busy cycle would be misread as the mailbox count, so the test exposes a busy window that is missing.
- Aborting a reply halfway with a soft reset, and writing an opcode during the settle, show that both reset kinds really drop engine state.

// File: rtl/hba_regport_pkg.sv
package hba_regport_pkg;

    localparam int BYTE_W  = 8;
    localparam int PAR_MAX = 5;

    localparam logic [1:0] ADR_CTL = 2'd0;
    localparam logic [1:0] ADR_CMD = 2'd1;
    localparam logic [1:0] ADR_INT = 2'd2;

    localparam logic [7:0] OPC_INIT24 = 8'h01;
    localparam logic [7:0] OPC_START  = 8'h02;
    localparam logic [7:0] OPC_BOARD  = 8'h04;
    localparam logic [7:0] OPC_SETUP  = 8'h0B;
    localparam logic [7:0] OPC_INIT32 = 8'h81;
    localparam logic [7:0] OPC_EXTINF = 8'h8D;

    localparam logic [7:0] MARK_EXT32 = 8'h45;
    localparam logic [7:0] MARK_NARROW = 8'h41;

    localparam int EXT_WIDE_IDX = 13;

    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_IDLE,
        ST_PARAM,
        ST_BUSY,
        ST_LOAD,
        ST_REPLY
    } eng_state_e;

endpackage

// File: rtl/hba_opc_table.sv
module hba_opc_table
    import hba_regport_pkg::*;
(
    input  logic [7:0] opc,
    output logic       known,
    output logic [2:0] npar,
    output logic [7:0] nrep
);
    always_comb begin
        known = 1'b1;
        npar  = 3'd0;
        nrep  = 8'd0;
        case (opc)
            OPC_INIT24: npar = 3'd4;
            OPC_INIT32: npar = 3'd5;
            OPC_BOARD:  nrep = 8'd4;
            OPC_SETUP:  nrep = 8'd3;
            OPC_EXTINF: npar = 3'd1;
            default:    known = 1'b0;
        endcase
    end
endmodule

// File: rtl/hba_reply_gen.sv
module hba_reply_gen
    import hba_regport_pkg::*;
(
    input  logic [7:0]  opc,
    input  logic [7:0]  idx,
    input  logic [31:0] cfg_board_id,
    input  logic [23:0] cfg_setup,
    input  logic        cfg_ext32,
    input  logic        cfg_wide,
    output logic [7:0]  byte_o
);
    always_comb begin
        byte_o = 8'h00;
        case (opc)
            OPC_BOARD: begin
                case (idx[1:0])
                    2'd0: byte_o = cfg_board_id[7:0];
                    2'd1: byte_o = cfg_board_id[15:8];
                    2'd2: byte_o = cfg_board_id[23:16];
                    default: byte_o = cfg_board_id[31:24];
                endcase
            end
            OPC_SETUP: begin
                case (idx[1:0])
                    2'd0: byte_o = cfg_setup[7:0];
                    2'd1: byte_o = cfg_setup[15:8];
                    default: byte_o = cfg_setup[23:16];
                endcase
            end
            OPC_EXTINF: begin
                if (idx == 8'd0)
                    byte_o = cfg_ext32 ? MARK_EXT32 : MARK_NARROW;
                else if (idx == 8'(EXT_WIDE_IDX))
                    byte_o = {7'b0, cfg_wide};
            end
            default: byte_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/hba_regport.sv
module hba_regport
    import hba_regport_pkg::*;
#(
    parameter int SETTLE_CYCLES = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq_o,
    input  logic        evt_in_loaded,
    input  logic        evt_out_ready,
    input  logic [31:0] cfg_board_id,
    input  logic [23:0] cfg_setup,
    input  logic        cfg_ext32,
    input  logic        cfg_wide,
    output logic        mbox_scan_o,
    output logic        scsi_bus_rst_o,
    output logic [7:0]  mbox_count_o,
    output logic [31:0] mbox_base_o,
    output logic        mbox_ext_o
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam int PAR_W = PAR_MAX * BYTE_W;

    typedef struct packed {
        eng_state_e        st;
        logic [7:0]        opc;
        logic              first;
        logic [7:0]        hold;
        logic [2:0]        par_left;
        logic [2:0]        par_idx;
        logic [PAR_W-1:0]  par;
        logic [7:0]        rep_len;
        logic [7:0]        rep_idx;
        logic [7:0]        din;
        logic              dirdy;
        logic              cmdinv;
        logic              initreq;
        logic              rdy;
        logic              diag;
        logic [3:0]        irq;
        logic [CNT_W-1:0]  cnt;
        logic              scan;
        logic              busrst;
        logic [7:0]        mb_cnt;
        logic [31:0]       mb_base;
        logic              mb_ext;
    } regs_t;

    regs_t q, d;

    logic       tb_known;
    logic [2:0] tb_npar;
    logic [7:0] tb_nrep;
    logic [7:0] rep_byte;
    logic [PAR_W-1:0] par_new;
    logic [7:0] stat_w;
    logic [7:0] intr_w;
    logic       wr_ctl, wr_cmd, rd_pop;

    hba_opc_table u_tab (
        .opc   (q.opc),
        .known (tb_known),
        .npar  (tb_npar),
        .nrep  (tb_nrep)
    );

    hba_reply_gen u_rep (
        .opc          (q.opc),
        .idx          (q.rep_idx),
        .cfg_board_id (cfg_board_id),
        .cfg_setup    (cfg_setup),
        .cfg_ext32    (cfg_ext32),
        .cfg_wide     (cfg_wide),
        .byte_o       (rep_byte)
    );

    assign wr_ctl = bus_wr && (bus_addr == ADR_CTL);
    assign wr_cmd = bus_wr && (bus_addr == ADR_CMD);
    assign rd_pop = bus_rd && (bus_addr == ADR_CMD);

    assign stat_w = {q.diag, 1'b0, q.initreq, q.rdy, (q.st == ST_BUSY),
                     q.dirdy, 1'b0, q.cmdinv};
    assign intr_w = {(|q.irq), 3'b000, q.irq};

    always_comb begin
        d = q;
        d.scan   = 1'b0;
        d.busrst = 1'b0;
        par_new  = q.par;
        par_new[int'(q.par_idx) * BYTE_W +: BYTE_W] = q.hold;

        if (wr_ctl && bus_wdata[7]) begin
            d.st      = ST_SETTLE;
            d.cnt     = CNT_W'(SETTLE_CYCLES);
            d.diag    = 1'b1;
            d.rdy     = 1'b0;
            d.initreq = 1'b0;
            d.irq     = 4'b0;
            d.dirdy   = 1'b0;
            d.cmdinv  = 1'b0;
            d.busrst  = bus_wdata[4];
        end else if (q.st == ST_SETTLE) begin
            if (q.cnt <= CNT_W'(1)) begin
                d.st      = ST_IDLE;
                d.diag    = 1'b0;
                d.rdy     = 1'b1;
                d.initreq = 1'b1;
                d.cnt     = '0;
            end else begin
                d.cnt = q.cnt - CNT_W'(1);
            end
        end else if (wr_ctl && bus_wdata[6]) begin
            d.st      = ST_IDLE;
            d.rdy     = 1'b1;
            d.initreq = 1'b1;
            d.irq     = 4'b0;
            d.dirdy   = 1'b0;
            d.cmdinv  = 1'b0;
            d.busrst  = bus_wdata[4];
        end else begin
            if (wr_ctl && bus_wdata[5])
                d.irq = 4'b0;
            if (wr_ctl && bus_wdata[4]) begin
                d.busrst = 1'b1;
                d.irq[3] = 1'b1;
            end
            if (evt_in_loaded)
                d.irq[0] = 1'b1;
            if (evt_out_ready)
                d.irq[1] = 1'b1;

            case (q.st)
                ST_IDLE: begin
                    if (wr_cmd) begin
                        if (bus_wdata == OPC_START) begin
                            d.scan = 1'b1;
                        end else begin
                            d.opc     = bus_wdata;
                            d.hold    = bus_wdata;
                            d.first   = 1'b1;
                            d.par_idx = 3'd0;
                            d.rdy     = 1'b0;
                            d.cmdinv  = 1'b0;
                            d.st      = ST_BUSY;
                        end
                    end
                end
                ST_PARAM: begin
                    if (wr_cmd) begin
                        d.hold  = bus_wdata;
                        d.first = 1'b0;
                        d.st    = ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (q.first) begin
                        if (!tb_known) begin
                            d.cmdinv = 1'b1;
                            d.irq[2] = 1'b1;
                            d.rdy    = 1'b1;
                            d.st     = ST_IDLE;
                        end else if (tb_npar != 3'd0) begin
                            d.par_left = tb_npar;
                            d.st       = ST_PARAM;
                        end else if (tb_nrep != 8'd0) begin
                            d.rep_len = tb_nrep;
                            d.rep_idx = 8'd0;
                            d.st      = ST_LOAD;
                        end else begin
                            d.irq[2] = 1'b1;
                            d.rdy    = 1'b1;
                            d.st     = ST_IDLE;
                        end
                    end else begin
                        d.par      = par_new;
                        d.par_idx  = q.par_idx + 3'd1;
                        d.par_left = q.par_left - 3'd1;
                        if (q.par_left == 3'd1) begin
                            d.irq[2] = 1'b1;
                            d.rdy    = 1'b1;
                            d.st     = ST_IDLE;
                            case (q.opc)
                                OPC_INIT24: begin
                                    d.mb_cnt  = par_new[7:0];
                                    d.mb_base = {8'h00, par_new[15:8],
                                                 par_new[23:16], par_new[31:24]};
                                    d.mb_ext  = 1'b0;
                                    d.initreq = 1'b0;
                                end
                                OPC_INIT32: begin
                                    d.mb_cnt  = par_new[7:0];
                                    d.mb_base = par_new[39:8];
                                    d.mb_ext  = 1'b1;
                                    d.initreq = 1'b0;
                                end
                                OPC_EXTINF: begin
                                    if (par_new[7:0] != 8'd0) begin
                                        d.irq[2]  = 1'b0;
                                        d.rdy     = 1'b0;
                                        d.rep_len = par_new[7:0];
                                        d.rep_idx = 8'd0;
                                        d.st      = ST_LOAD;
                                    end
                                end
                                default: ;
                            endcase
                        end else begin
                            d.st = ST_PARAM;
                        end
                    end
                end
                ST_LOAD: begin
                    d.din   = rep_byte;
                    d.dirdy = 1'b1;
                    d.st    = ST_REPLY;
                end
                ST_REPLY: begin
                    if (rd_pop) begin
                        d.dirdy = 1'b0;
                        if ((q.rep_idx + 8'd1) == q.rep_len) begin
                            d.irq[2] = 1'b1;
                            d.rdy    = 1'b1;
                            d.st     = ST_IDLE;
                        end else begin
                            d.rep_idx = q.rep_idx + 8'd1;
                            d.st      = ST_LOAD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_SETTLE;
            q.diag <= 1'b1;
            q.cnt  <= CNT_W'(SETTLE_CYCLES);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (bus_addr)
            ADR_CTL: bus_rdata = stat_w;
            ADR_CMD: bus_rdata = q.din;
            ADR_INT: bus_rdata = intr_w;
            default: bus_rdata = 8'h00;
        endcase
    end

    assign irq_o          = intr_w[7];
    assign mbox_scan_o    = q.scan;
    assign scsi_bus_rst_o = q.busrst;
    assign mbox_count_o   = q.mb_cnt;
    assign mbox_base_o    = q.mb_base;
    assign mbox_ext_o     = q.mb_ext;

endmodule

// File: rtl/hba_regport_chk.sv
module hba_regport_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] stat,
    input logic [7:0] intr,
    input logic       scan
);
    // R1
    diag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[7] |-> (stat[5:3] == 3'b000));

    // R2
    hard_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 2'd0 && bus_wdata[7]) |=> (stat == 8'h80 && intr == 8'h00));

    // R6
    busy_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[3] |=> !stat[3]);

    // R6
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[3] |-> !stat[4]);

    // R11
    pop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 2'd1 && stat[2] && !(bus_wr && bus_addr == 2'd0 && bus_wdata[7]))
        |=> !stat[2]);

    // R12
    scan_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan |=> !scan);

    // R12
    scan_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan |-> stat[4]);

    // R13
    invalid_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> (intr[2] && stat[4]));
endmodule

bind hba_regport hba_regport_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .stat      (stat_w),
    .intr      (intr_w),
    .scan      (mbox_scan_o)
);

// File: tb/hba_regport_bench.sv
module hba_regport_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE     = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        irq_o;
    logic        evt_in_loaded = 1'b0;
    logic        evt_out_ready = 1'b0;
    logic [31:0] cfg_board_id = 32'h4433_2211;
    logic [23:0] cfg_setup = 24'hC0_FFEE;
    logic        cfg_ext32 = 1'b1;
    logic        cfg_wide = 1'b1;
    logic        mbox_scan_o;
    logic        scsi_bus_rst_o;
    logic [7:0]  mbox_count_o;
    logic [31:0] mbox_base_o;
    logic        mbox_ext_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    hba_regport #(.SETTLE_CYCLES(SETTLE)) u_hba_regport (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_wr         (bus_wr),
        .bus_rd         (bus_rd),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .irq_o          (irq_o),
        .evt_in_loaded  (evt_in_loaded),
        .evt_out_ready  (evt_out_ready),
        .cfg_board_id   (cfg_board_id),
        .cfg_setup      (cfg_setup),
        .cfg_ext32      (cfg_ext32),
        .cfg_wide       (cfg_wide),
        .mbox_scan_o    (mbox_scan_o),
        .scsi_bus_rst_o (scsi_bus_rst_o),
        .mbox_count_o   (mbox_count_o),
        .mbox_base_o    (mbox_base_o),
        .mbox_ext_o     (mbox_ext_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic reg_pop(output logic [7:0] v);
        bus_addr = 2'd1;
        bus_rd   = 1'b1;
        #1;
        v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_reg(input logic [1:0] a, input logic [7:0] mask,
                            input logic [7:0] val, input string tag);
        logic [7:0] v;
        bit ok = 1'b0;
        for (int i = 0; i < 40; i++) begin
            peek(a, v);
            if ((v & mask) == val) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        check({tag, " wait"}, 32'(ok), 32'd1);
    endtask

    task automatic run_cmd(input logic [7:0] opc, input int np, input logic [39:0] p);
        reg_wr(2'd1, opc);
        for (int i = 0; i < np; i++) begin
            wait_reg(2'd0, 8'h08, 8'h00, "param");
            reg_wr(2'd1, p[8*i +: 8]);
        end
    endtask

    task automatic get_byte(input string tag, input logic [7:0] exp);
        logic [7:0] v;
        wait_reg(2'd0, 8'h04, 8'h04, tag);
        reg_pop(v);
        check(tag, 32'(v), 32'(exp));
    endtask

    task automatic clear_int();
        logic [7:0] v;
        reg_wr(2'd0, 8'h20);
        peek(2'd2, v);
        check("R4 clear", 32'(v), 32'h00);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        peek(2'd0, v);
        check("R1 status at release", 32'(v), 32'h80);
        peek(2'd2, v);
        check("R1 interrupt at release", 32'(v), 32'h00);
        repeat (SETTLE - 1) @(negedge clk);
        peek(2'd0, v);
        check("R1 status last settle cycle", 32'(v), 32'h80);
        @(negedge clk);
        peek(2'd0, v);
        check("R1 status after settle", 32'(v), 32'h30);
    endtask

    task automatic t_init24();
        logic [7:0] v;
        reg_wr(2'd1, 8'h01);
        peek(2'd0, v);
        check("R6 busy and not ready", 32'(v & 8'h18), 32'h08);
        reg_wr(2'd1, 8'hAA);
        peek(2'd0, v);
        check("R6 busy one cycle", 32'(v & 8'h18), 32'h00);
        for (int i = 0; i < 4; i++) begin
            wait_reg(2'd0, 8'h08, 8'h00, "R7 param");
            reg_wr(2'd1, (i == 0) ? 8'h10 : (i == 1) ? 8'h12 : (i == 2) ? 8'h34 : 8'h56);
        end
        wait_reg(2'd2, 8'h04, 8'h04, "R7 complete");
        peek(2'd2, v);
        check("R7 interrupt", 32'(v), 32'h84);
        peek(2'd0, v);
        check("R7 status", 32'(v), 32'h10);
        check("R7 count (R6 ignored byte)", 32'(mbox_count_o), 32'h10);
        check("R7 base", mbox_base_o, 32'h0012_3456);
        check("R7 ext", 32'(mbox_ext_o), 32'd0);
        check("R5 irq", 32'(irq_o), 32'd1);
    endtask

    task automatic t_init32();
        logic [7:0] v;
        clear_int();
        check("R5 irq cleared", 32'(irq_o), 32'd0);
        reg_wr(2'd0, 8'h40);
        run_cmd(8'h81, 5, 40'h12_34_56_78_20);
        wait_reg(2'd2, 8'h04, 8'h04, "R8 complete");
        peek(2'd0, v);
        check("R8 status", 32'(v), 32'h10);
        check("R8 count", 32'(mbox_count_o), 32'h20);
        check("R8 base", mbox_base_o, 32'h1234_5678);
        check("R8 ext", 32'(mbox_ext_o), 32'd1);
    endtask

    task automatic t_board();
        logic [7:0] v;
        clear_int();
        run_cmd(8'h04, 0, 40'h0);
        for (int i = 0; i < 4; i++) begin
            get_byte("R9 board byte", cfg_board_id[8*i +: 8]);
            peek(2'd0, v);
            check("R11 ready flag cleared by read", 32'(v & 8'h04), 32'h00);
            peek(2'd2, v);
            check("R11 complete only after last", 32'(v), (i == 3) ? 32'h84 : 32'h00);
        end
        clear_int();
        run_cmd(8'h0B, 0, 40'h0);
        get_byte("R9 setup byte0", 8'hEE);
        get_byte("R9 setup byte1", 8'hFF);
        get_byte("R9 setup byte2", 8'hC0);
        peek(2'd2, v);
        check("R9 setup complete", 32'(v), 32'h84);
    endtask

    task automatic t_extinfo();
        logic [7:0] v;
        clear_int();
        cfg_ext32 = 1'b1;
        cfg_wide  = 1'b1;
        run_cmd(8'h8D, 1, 40'h0E);
        for (int i = 0; i < 14; i++)
            get_byte("R10 ext byte", (i == 0) ? 8'h45 : (i == 13) ? 8'h01 : 8'h00);
        peek(2'd2, v);
        check("R10 complete", 32'(v), 32'h84);
        clear_int();
        cfg_ext32 = 1'b0;
        cfg_wide  = 1'b0;
        run_cmd(8'h8D, 1, 40'h02);
        get_byte("R10 narrow byte0", 8'h41);
        get_byte("R10 narrow byte1", 8'h00);
        clear_int();
        run_cmd(8'h8D, 1, 40'h00);
        wait_reg(2'd2, 8'h04, 8'h04, "R10 zero length");
        peek(2'd0, v);
        check("R10 zero length no data", 32'(v & 8'h1C), 32'h10);
    endtask

    task automatic t_start();
        logic [7:0] v;
        clear_int();
        reg_wr(2'd1, 8'h02);
        check("R12 scan pulse", 32'(mbox_scan_o), 32'd1);
        peek(2'd0, v);
        check("R12 ready kept", 32'(v & 8'h18), 32'h10);
        @(negedge clk);
        check("R12 scan one cycle", 32'(mbox_scan_o), 32'd0);
        peek(2'd2, v);
        check("R12 no completion", 32'(v), 32'h00);
    endtask

    task automatic t_invalid();
        logic [7:0] v;
        clear_int();
        reg_wr(2'd1, 8'h77);
        wait_reg(2'd2, 8'h04, 8'h04, "R13 complete");
        peek(2'd0, v);
        check("R13 invalid status", 32'(v), 32'h11);
        peek(2'd2, v);
        check("R13 interrupt", 32'(v), 32'h84);
        clear_int();
        reg_wr(2'd1, 8'h0B);
        peek(2'd0, v);
        check("R13 invalid cleared by next opcode", 32'(v & 8'h01), 32'h00);
        for (int i = 0; i < 3; i++)
            get_byte("R13 next command works", cfg_setup[8*i +: 8]);
    endtask

    task automatic t_busrst();
        logic [7:0] v;
        clear_int();
        reg_wr(2'd0, 8'h10);
        check("R4 bus reset pulse", 32'(scsi_bus_rst_o), 32'd1);
        peek(2'd2, v);
        check("R4 reset seen", 32'(v), 32'h88);
        check("R5 irq on reset seen", 32'(irq_o), 32'd1);
        @(negedge clk);
        check("R4 pulse one cycle", 32'(scsi_bus_rst_o), 32'd0);
        clear_int();
        check("R5 irq dropped", 32'(irq_o), 32'd0);
    endtask

    task automatic t_events();
        logic [7:0] v;
        evt_in_loaded = 1'b1;
        @(negedge clk);
        evt_in_loaded = 1'b0;
        peek(2'd2, v);
        check("R14 incoming loaded", 32'(v), 32'h81);
        evt_out_ready = 1'b1;
        @(negedge clk);
        evt_out_ready = 1'b0;
        peek(2'd2, v);
        check("R14 outgoing ready", 32'(v), 32'h83);
    endtask

    task automatic t_soft();
        logic [7:0] v;
        run_cmd(8'h04, 0, 40'h0);
        get_byte("R3 first byte", cfg_board_id[7:0]);
        wait_reg(2'd0, 8'h04, 8'h04, "R3 second ready");
        reg_wr(2'd0, 8'h40);
        peek(2'd0, v);
        check("R3 status after soft", 32'(v), 32'h30);
        peek(2'd2, v);
        check("R3 interrupt after soft", 32'(v), 32'h00);
        run_cmd(8'h0B, 0, 40'h0);
        get_byte("R3 fresh command", cfg_setup[7:0]);
        get_byte("R3 fresh command", cfg_setup[15:8]);
        get_byte("R3 fresh command", cfg_setup[23:16]);
    endtask

    task automatic t_hard();
        logic [7:0] v;
        reg_wr(2'd0, 8'h80);
        peek(2'd0, v);
        check("R2 status in settle", 32'(v), 32'h80);
        peek(2'd2, v);
        check("R2 interrupt cleared", 32'(v), 32'h00);
        reg_wr(2'd1, 8'h04);
        wait_reg(2'd0, 8'hFF, 8'h30, "R2 settle end");
        repeat (3) @(negedge clk);
        peek(2'd0, v);
        check("R2 opcode during settle ignored", 32'(v), 32'h30);
        peek(2'd2, v);
        check("R2 no completion", 32'(v), 32'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_init24();
        t_init32();
        t_board();
        t_extinfo();
        t_start();
        t_invalid();
        t_busrst();
        t_events();
        t_soft();
        t_hard();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end
endmodule